// File: doc/BRIEF.md
# Menu-Driven SPI Flash Cycle Engine

This block runs one serial-flash cycle each time software asks for it. Software first loads a small table of permitted opcodes, a type table that gives each opcode's cycle shape, a 24-bit flash address, a 64-byte data buffer and an optional prefix opcode. It then writes a control word that picks a table entry, gives the data byte count minus one, enables or disables the data phase, optionally asks for an atomic prefix, and sets a go bit. The engine drives a single-bit SPI master (clock idle low, data launched on the falling edge and sampled on the rising edge). It sends the opcode, then three address bytes when the type calls for them, then either sends bytes from the buffer or stores captured bytes back into it.

Each table entry's 2-bit type picks one of four cycle shapes. Bit 0 selects the data direction and bit 1 selects whether an address phase is present. When a prefix is requested and the prefix register is nonzero, the prefix opcode goes out as a separate one-byte chip-select frame. The main frame follows after a short, fixed chip-select-high gap, and no other cycle can start between the two. A lock bit, once set, freezes the opcode table, the type table and the prefix register until reset.

Top module: `flash_cycle_engine`

## Requirements
- R1: After reset the status word reads 0 (not busy, no done, no error, unlocked), chip select is high and the serial clock is low. The serial clock is low whenever chip select is high.
- R2: The opcode sent first in the main frame is opcode table entry n, where n is control bits 6:4. Entry n's type is taken from type-table bits 2n+1:2n. Types: 0 read without address, 1 write without address, 2 read with address, 3 write with address.
- R3: For types 2 and 3, the three bytes after the opcode are address bits 23:16, 15:8 and 7:0 in that order. Address register bits 31:24 have no effect. Types 0 and 1 send no address.
- R4: With the data-enable bit (control bit 14) set, a write type sends count+1 bytes from buffer bytes 0 upward, where count is control bits 13:8. Up to 64 bytes are allowed. With data-enable clear, the frame ends after the opcode or address. Buffer byte k sits in buffer word k/4 at bits 8*(k%4)+7:8*(k%4).
- R5: With data-enable set, a read type clocks count+1 bytes in, sampling the input on rising clock edges, most significant bit first. It stores them in buffer bytes 0 upward. The bytes it sends during this phase are 0x00, and buffer bytes past count are unchanged.
- R6: Status bit 0 (busy) reads 1 from the go write until the cycle ends. Status bit 2 (done) is set when the cycle ends.
- R7: Writing 1 to status bit 2 clears done and writing 1 to status bit 3 clears error. Each bit is cleared independently of the other.
- R8: A go (control bit 1) written while busy, or one that selects an entry at or beyond the table size (6), sets status bit 3. No frame is started and any running cycle is unaffected.
- R9: With control bit 2 set and a nonzero prefix register, the prefix opcode is sent alone in its own frame immediately before the main frame, with chip select high for at least 2 clocks between them. With the prefix register zero, only the main frame is sent.
- R10: Writing 1 to status bit 15 sets the lock, which stays set until reset. While locked, writes to the opcode table, type table and prefix register are ignored, and cycles use the frozen contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address: 0 control, 1 status, 2 address, 3 prefix, 4 types, 5-6 opcode table, 16-31 buffer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A table of eight cycles covers all four types. It uses different table entries, data lengths of 1, 3, 4, 8 and the full 64 bytes, and data-enable both off and on. This separates the address-phase decision from the direction decision and the count decode from the buffer order. The type table is filled with the wanted type only in the selected entry's field and the complement everywhere else, so a wrong field position shows up as a wrong frame shape. Because the input pattern changes with each byte position, a read that captures a byte early or late is detected. Directed runs cover go while busy, an out-of-range entry, a prefix with and without a zero prefix register, independent clearing of the status bits, and writes attempted after locking.

// File: rtl/fce_pkg.sv
// Package: shared constants, field positions and types for the flash cycle engine.
// Assumes a 64-byte data buffer and 32-bit host registers.
package fce_pkg;
    localparam int BUF_BYTES = 64;
    localparam int BUF_IW    = $clog2(BUF_BYTES);
    localparam int BUF_WORDS = BUF_BYTES / 4;
    localparam int REG_AW    = $clog2(BUF_WORDS) + 1;
    localparam int CNT_W     = BUF_IW;

    // control word fields
    localparam int CTL_GO      = 1;
    localparam int CTL_ATOMIC  = 2;
    localparam int CTL_IDX_LSB = 4;
    localparam int CTL_CNT_LSB = 8;
    localparam int CTL_DEN     = CTL_CNT_LSB + CNT_W;

    // status word fields
    localparam int ST_BUSY = 0;
    localparam int ST_DONE = 2;
    localparam int ST_ERR  = 3;
    localparam int ST_LOCK = 15;

    // register word addresses (buffer occupies the upper half)
    localparam int RA_CTRL   = 0;
    localparam int RA_STAT   = 1;
    localparam int RA_ADDR   = 2;
    localparam int RA_PREFIX = 3;
    localparam int RA_TYPES  = 4;
    localparam int RA_MENU0  = 5;

    typedef enum logic [1:0] {
        OP_RD_NOADDR = 2'd0,
        OP_WR_NOADDR = 2'd1,
        OP_RD_ADDR   = 2'd2,
        OP_WR_ADDR   = 2'd3
    } op_kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_PRE, S_GAP, S_OPC, S_ADR, S_DAT, S_END
    } seq_state_e;

    typedef struct packed {
        logic [7:0]       opcode;
        op_kind_e         kind;
        logic [23:0]      addr;
        logic             den;
        logic [CNT_W-1:0] cnt;
        logic             pre_en;
        logic [7:0]       pre_op;
    } cycle_req_t;
endpackage

// File: rtl/fce_shift.sv
// Module: single-byte SPI shifter, clock idle low, launch on falling edge,
// sample on rising edge, MSB first. Assumes start is only pulsed when idle.
// done pulses for one clock after the eighth falling edge; rx is valid then.
module fce_shift #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       done,
    output logic [7:0] rx,
    output logic       sck,
    output logic       mosi
);
    localparam int DIV_W = $clog2(HALF_DIV) + 1;

    logic             active;
    logic [7:0]       shreg;
    logic             rbit;
    logic [2:0]       bitn;
    logic [DIV_W-1:0] div;

    // Purpose: divide the clock, toggle sck, sample on rise, shift on fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            shreg  <= '0;
            rbit   <= 1'b0;
            bitn   <= '0;
            div    <= '0;
            sck    <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active <= 1'b1;
                shreg  <= tx;
                bitn   <= '0;
                div    <= '0;
                sck    <= 1'b0;
            end else if (active) begin
                if (div == DIV_W'(HALF_DIV - 1)) begin
                    div <= '0;
                    sck <= ~sck;
                    if (!sck) begin
                        rbit <= miso;
                    end else begin
                        shreg <= {shreg[6:0], rbit};
                        if (bitn == 3'd7) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            bitn <= bitn + 3'd1;
                        end
                    end
                end else begin
                    div <= div + DIV_W'(1);
                end
            end
        end
    end

    assign mosi = shreg[7];
    assign rx   = shreg;

    // R5: a new byte is only launched once the previous one has finished
    p_start_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active);
endmodule

// File: rtl/fce_regs.sv
// Module: host register file, opcode/type tables, lock, status and data buffer.
// Assumes single-cycle host writes; reads are combinational on addr.
// Produces a go pulse with the fully resolved cycle request when a go is legal.
module fce_regs import fce_pkg::*; #(
    parameter int MENU_ENTRIES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              busy,
    input  logic              seq_done,
    input  logic              buf_we,
    input  logic [BUF_IW-1:0] buf_widx,
    input  logic [7:0]        buf_wdat,
    input  logic [BUF_IW-1:0] buf_ridx,
    output logic [7:0]        buf_rdat,
    output logic              go,
    output cycle_req_t        req
);
    localparam int TYPE_W     = 2 * MENU_ENTRIES;
    localparam int MENU_WORDS = (MENU_ENTRIES + 3) / 4;

    logic [7:0]        menu_q [MENU_ENTRIES];
    logic [TYPE_W-1:0] types_q;
    logic [7:0]        prefix_q;
    logic [31:0]       addr_q;
    logic [15:0]       ctrl_q;
    logic              done_q, err_q, lock_q;
    logic [7:0]        buf_q [BUF_BYTES];

    logic              wr_ctrl, wr_stat, go_req, in_rng, buf_hit;
    logic [2:0]        idx;
    logic [REG_AW-2:0] bword;

    assign wr_ctrl = we && (addr == REG_AW'(RA_CTRL));
    assign wr_stat = we && (addr == REG_AW'(RA_STAT));
    assign idx     = wdata[CTL_IDX_LSB +: 3];
    assign go_req  = wr_ctrl && wdata[CTL_GO];
    assign in_rng  = ({29'd0, idx} < 32'(MENU_ENTRIES));
    assign go      = go_req && !busy && in_rng;
    assign buf_hit = addr[REG_AW-1];
    assign bword   = addr[REG_AW-2:0];

    // Purpose: resolve the opcode and type of the selected entry for the request.
    always_comb begin
        req        = '0;
        req.addr   = addr_q[23:0];
        req.den    = wdata[CTL_DEN];
        req.cnt    = wdata[CTL_CNT_LSB +: CNT_W];
        req.pre_en = wdata[CTL_ATOMIC] && (prefix_q != 8'd0);
        req.pre_op = prefix_q;
        for (int i = 0; i < MENU_ENTRIES; i++) begin
            if (idx == 3'(i)) begin
                req.opcode = menu_q[i];
                req.kind   = op_kind_e'(types_q[2*i +: 2]);
            end
        end
    end

    // Purpose: control, address and status registers with write-1-to-clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            addr_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            lock_q <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata[15:0] & ~(16'd1 << CTL_GO);
            if (we && addr == REG_AW'(RA_ADDR)) addr_q <= wdata;
            if (seq_done) done_q <= 1'b1;
            else if (wr_stat && wdata[ST_DONE]) done_q <= 1'b0;
            if (go_req && !go) err_q <= 1'b1;
            else if (wr_stat && wdata[ST_ERR]) err_q <= 1'b0;
            if (wr_stat && wdata[ST_LOCK]) lock_q <= 1'b1;
        end
    end

    // Purpose: lockable opcode table, type table and prefix register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            types_q  <= '0;
            prefix_q <= '0;
            for (int i = 0; i < MENU_ENTRIES; i++) menu_q[i] <= '0;
        end else if (we && !lock_q) begin
            if (addr == REG_AW'(RA_TYPES))  types_q  <= wdata[TYPE_W-1:0];
            if (addr == REG_AW'(RA_PREFIX)) prefix_q <= wdata[7:0];
            for (int i = 0; i < MENU_ENTRIES; i++) begin
                if (addr == REG_AW'(RA_MENU0 + i / 4)) menu_q[i] <= wdata[8*(i%4) +: 8];
            end
        end
    end

    // Purpose: data buffer, engine byte port has priority over host word writes.
    always_ff @(posedge clk) begin
        if (buf_we) begin
            buf_q[buf_widx] <= buf_wdat;
        end else if (we && buf_hit) begin
            for (int b = 0; b < 4; b++) buf_q[{bword, 2'(b)}] <= wdata[8*b +: 8];
        end
    end

    assign buf_rdat = buf_q[buf_ridx];

    // Purpose: host read multiplexer.
    always_comb begin
        rdata = '0;
        if (buf_hit) begin
            for (int b = 0; b < 4; b++) rdata[8*b +: 8] = buf_q[{bword, 2'(b)}];
        end else begin
            if (addr == REG_AW'(RA_CTRL))   rdata = {16'd0, ctrl_q};
            if (addr == REG_AW'(RA_STAT))   rdata = {16'd0, lock_q, 11'd0, err_q, done_q, 1'b0, busy};
            if (addr == REG_AW'(RA_ADDR))   rdata = addr_q;
            if (addr == REG_AW'(RA_PREFIX)) rdata = {24'd0, prefix_q};
            if (addr == REG_AW'(RA_TYPES))  rdata = 32'(types_q);
            for (int w = 0; w < MENU_WORDS; w++) begin
                if (addr == REG_AW'(RA_MENU0 + w)) begin
                    for (int b = 0; b < 4; b++) begin
                        if (4*w + b < MENU_ENTRIES) rdata[8*b +: 8] = menu_q[4*w + b];
                    end
                end
            end
        end
    end

    // R10: lock is sticky once set
    p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);
    // R10: locked tables do not change
    p_tables_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> ($stable(types_q) && $stable(prefix_q)));
    // R8: go while busy raises the error flag
    p_busy_go_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (go_req && busy) |=> err_q);
endmodule

// File: rtl/fce_seq.sv
// Module: cycle sequencer. Latches the request at go, then walks the prefix
// frame, chip-select gap, opcode, address and data phases one byte at a time.
// Assumes the shifter answers every start with exactly one done pulse.
module fce_seq import fce_pkg::*; #(
    parameter int GAP_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  cycle_req_t        req,
    output logic              busy,
    output logic              done,
    output logic              cs_n,
    output logic              sh_start,
    output logic [7:0]        sh_tx,
    input  logic              sh_done,
    input  logic [7:0]        sh_rx,
    output logic [BUF_IW-1:0] buf_ridx,
    input  logic [7:0]        buf_rdat,
    output logic              buf_we,
    output logic [BUF_IW-1:0] buf_widx,
    output logic [7:0]        buf_wdat
);
    localparam int GAP_W = $clog2(GAP_CLKS + 1);

    seq_state_e       st;
    cycle_req_t       cur;
    logic             issued;
    logic [CNT_W-1:0] bcnt;
    logic [GAP_W-1:0] gcnt;
    logic             byte_st;

    assign byte_st  = (st == S_PRE) || (st == S_OPC) || (st == S_ADR) || (st == S_DAT);
    assign sh_start = byte_st && !issued;
    assign cs_n     = !byte_st;
    assign busy     = (st != S_IDLE);
    assign done     = (st == S_END);
    assign buf_ridx = bcnt;
    assign buf_widx = bcnt;
    assign buf_wdat = sh_rx;
    assign buf_we   = (st == S_DAT) && sh_done && !cur.kind[0];

    // Purpose: select the byte to transmit for the current phase.
    always_comb begin
        sh_tx = 8'h00;
        case (st)
            S_PRE: sh_tx = cur.pre_op;
            S_OPC: sh_tx = cur.opcode;
            S_ADR: begin
                case (bcnt[1:0])
                    2'd0:    sh_tx = cur.addr[23:16];
                    2'd1:    sh_tx = cur.addr[15:8];
                    default: sh_tx = cur.addr[7:0];
                endcase
            end
            S_DAT: sh_tx = cur.kind[0] ? buf_rdat : 8'h00;
            default: sh_tx = 8'h00;
        endcase
    end

    // Purpose: phase state machine with byte and gap counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            cur    <= '0;
            issued <= 1'b0;
            bcnt   <= '0;
            gcnt   <= '0;
        end else begin
            if (sh_start) issued <= 1'b1;
            else if (sh_done) issued <= 1'b0;
            case (st)
                S_IDLE: if (go) begin
                    cur  <= req;
                    bcnt <= '0;
                    st   <= req.pre_en ? S_PRE : S_OPC;
                end
                S_PRE: if (sh_done) begin
                    gcnt <= '0;
                    st   <= S_GAP;
                end
                S_GAP: begin
                    if (gcnt == GAP_W'(GAP_CLKS - 1)) st <= S_OPC;
                    else gcnt <= gcnt + GAP_W'(1);
                end
                S_OPC: if (sh_done) begin
                    bcnt <= '0;
                    if (cur.kind[1])  st <= S_ADR;
                    else if (cur.den) st <= S_DAT;
                    else              st <= S_END;
                end
                S_ADR: if (sh_done) begin
                    if (bcnt == CNT_W'(2)) begin
                        bcnt <= '0;
                        st   <= cur.den ? S_DAT : S_END;
                    end else begin
                        bcnt <= bcnt + CNT_W'(1);
                    end
                end
                S_DAT: if (sh_done) begin
                    if (bcnt == cur.cnt) st <= S_END;
                    else bcnt <= bcnt + CNT_W'(1);
                end
                S_END:   st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_cycle_engine.sv
// Module: top of the menu-driven SPI flash cycle engine. Connects the host
// register file, the cycle sequencer and the byte shifter.
// Assumes a single attached flash and a fixed serial clock divider.
module flash_cycle_engine import fce_pkg::*; #(
    parameter int MENU_ENTRIES = 6,
    parameter int HALF_DIV     = 2,
    parameter int GAP_CLKS     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic              go, busy, seq_done, sh_start, sh_done;
    cycle_req_t        req;
    logic [7:0]        sh_tx, sh_rx, buf_rdat, buf_wdat;
    logic              buf_we;
    logic [BUF_IW-1:0] buf_ridx, buf_widx;

    fce_regs #(.MENU_ENTRIES(MENU_ENTRIES)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy), .seq_done(seq_done),
        .buf_we(buf_we), .buf_widx(buf_widx), .buf_wdat(buf_wdat),
        .buf_ridx(buf_ridx), .buf_rdat(buf_rdat), .go(go), .req(req)
    );

    fce_seq #(.GAP_CLKS(GAP_CLKS)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .req(req), .busy(busy),
        .done(seq_done), .cs_n(spi_cs_n), .sh_start(sh_start), .sh_tx(sh_tx),
        .sh_done(sh_done), .sh_rx(sh_rx), .buf_ridx(buf_ridx),
        .buf_rdat(buf_rdat), .buf_we(buf_we), .buf_widx(buf_widx),
        .buf_wdat(buf_wdat)
    );

    fce_shift #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx(sh_tx),
        .miso(spi_miso), .done(sh_done), .rx(sh_rx), .sck(spi_sck),
        .mosi(spi_mosi)
    );

    // R1: the serial clock rests low whenever the flash is deselected
    p_sck_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);
    // R9: chip select stays high for at least two clocks once it rises
    p_cs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |=> spi_cs_n);
endmodule

// File: tb/test_flash_cycle_engine.sv
module test_flash_cycle_engine;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [4:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    flash_cycle_engine i_flash_cycle_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // flash model: capture MOSI frames, drive MISO response pattern
    logic [7:0] fr_byte [32][80];
    int         fr_len [32];
    int         gap_before [32];
    int         nfr = 0;
    int         cap_bits = 0;
    logic [7:0] cap_sh = 8'd0;
    logic       cs_last = 1'b1;

    function automatic logic [7:0] resp(input int k);
        return 8'h3C + 8'(k * 17);
    endfunction

    always @(posedge spi_sck or negedge spi_sck or negedge spi_cs_n or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            if (!cs_last) nfr = nfr + 1;
            cs_last = 1'b1;
        end else begin
            if (cs_last) begin
                cap_bits = 0;
                fr_len[nfr] = 0;
            end
            cs_last = 1'b0;
            if (spi_sck) begin
                cap_sh = {cap_sh[6:0], spi_mosi};
                cap_bits = cap_bits + 1;
                if (cap_bits % 8 == 0) begin
                    fr_byte[nfr][fr_len[nfr]] = cap_sh;
                    fr_len[nfr] = fr_len[nfr] + 1;
                end
            end else begin
                spi_miso = resp(cap_bits / 8)[7 - (cap_bits % 8)];
            end
        end
    end

    int   hi_run = 0;
    logic prev_cs = 1'b1;
    always @(negedge clk) begin
        if (spi_cs_n) hi_run = hi_run + 1;
        else begin
            if (prev_cs) gap_before[nfr] = hi_run;
            hi_run = 0;
        end
        prev_cs = spi_cs_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 5'(a);
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(1, s);
            if (!s[0]) break;
        end
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] ctl(input int idx, input bit den, input int cnt, input bit atomic);
        return (32'd1 << 1) | (32'(atomic) << 2) | (32'(idx) << 4) | (32'(cnt) << 8) | (32'(den) << 14);
    endfunction

    function automatic logic [7:0] fill(input int v, input int j);
        return 8'(j * 7 + v * 3 + 1);
    endfunction

    // vector fields: idx[36:34] kind[33:32] addr[31:8] den[7] cnt[6:1] atomic[0]
    localparam logic [36:0] VEC [8] = '{
        {3'd0, 2'd2, 24'h123456, 1'b1, 6'd3,  1'b0},
        {3'd3, 2'd3, 24'hABCDEF, 1'b1, 6'd7,  1'b0},
        {3'd1, 2'd0, 24'h000000, 1'b1, 6'd2,  1'b0},
        {3'd5, 2'd1, 24'h000000, 1'b0, 6'd0,  1'b0},
        {3'd2, 2'd3, 24'h000100, 1'b1, 6'd63, 1'b0},
        {3'd4, 2'd2, 24'hFFFFFF, 1'b1, 6'd0,  1'b0},
        {3'd2, 2'd3, 24'h00FF00, 1'b0, 6'd0,  1'b0},
        {3'd1, 2'd2, 24'h010203, 1'b1, 6'd1,  1'b1}
    };

    task automatic run_vec(input int v);
        logic [36:0] vec;
        int idx, kind, cnt, base, nexp, m, hdr, len, bad;
        bit den, atomic;
        logic [23:0] adr;
        logic [11:0] types;
        logic [31:0] s, w;
        vec = VEC[v];
        idx = int'(vec[36:34]); kind = int'(vec[33:32]); adr = vec[31:8];
        den = vec[7]; cnt = int'(vec[6:1]); atomic = vec[0];
        for (int i = 0; i < 6; i++) types[2*i +: 2] = (i == idx) ? 2'(kind) : ~2'(kind);
        wr(4, 32'(types));
        for (int k = 0; k < 16; k++)
            wr(16 + k, {fill(v, 4*k+3), fill(v, 4*k+2), fill(v, 4*k+1), fill(v, 4*k)});
        wr(2, {8'hA5, adr});
        base = nfr;
        wr(0, ctl(idx, den, cnt, atomic));
        rd(1, s);
        chk(s[0] == 1'b1, "R6 busy during cycle", int'(s[0]), 1);
        wait_idle();
        nexp = atomic ? 2 : 1;
        chk(nfr - base == nexp, "R9 frame count", nfr - base, nexp);
        if (atomic) begin
            chk(fr_len[base] == 1 && fr_byte[base][0] == 8'h06, "R9 prefix frame", int'(fr_byte[base][0]), 8'h06);
            chk(gap_before[base+1] >= 2, "R9 cs gap", gap_before[base+1], 2);
        end
        m = base + nexp - 1;
        hdr = (kind >= 2) ? 4 : 1;
        len = hdr + (den ? cnt + 1 : 0);
        chk(fr_len[m] == len, "R4 frame length", fr_len[m], len);
        chk(fr_byte[m][0] == 8'(8'h11 * (idx + 1)), "R2 opcode", int'(fr_byte[m][0]), int'(8'(8'h11 * (idx + 1))));
        if (kind >= 2) begin
            bad = 0;
            if (fr_byte[m][1] != adr[23:16]) bad++;
            if (fr_byte[m][2] != adr[15:8]) bad++;
            if (fr_byte[m][3] != adr[7:0]) bad++;
            chk(bad == 0, "R3 address bytes", int'({fr_byte[m][1], fr_byte[m][2], fr_byte[m][3]}), int'(adr));
        end
        if (den) begin
            bad = 0;
            for (int j = 0; j <= cnt; j++)
                if (fr_byte[m][hdr+j] != ((kind % 2 == 1) ? fill(v, j) : 8'h00)) bad++;
            chk(bad == 0, "R4 data bytes sent", bad, 0);
            if (kind % 2 == 0) begin
                bad = 0;
                for (int k = 0; k < 16; k++) begin
                    rd(16 + k, w);
                    for (int b = 0; b < 4; b++) begin
                        if (4*k + b <= cnt) begin
                            if (w[8*b +: 8] != resp(hdr + 4*k + b)) bad++;
                        end else if (w[8*b +: 8] != fill(v, 4*k + b)) bad++;
                    end
                end
                chk(bad == 0, "R5 read data in buffer", bad, 0);
            end
        end
        rd(1, s);
        chk(s[2] == 1'b1 && s[0] == 1'b0, "R6 done set, busy clear", int'(s[3:0]), 4);
        wr(1, 32'h4);
    endtask

    initial begin
        logic [31:0] s;
        int base;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        rd(1, s);
        chk(s == 32'd0, "R1 status after reset", int'(s), 0);
        chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 idle pins", int'({spi_cs_n, spi_sck}), 2);

        wr(5, 32'h44332211);
        wr(6, 32'h00006655);
        wr(3, 32'h06);
        for (int v = 0; v < 8; v++) run_vec(v);

        // R8 / R7: go while busy
        wr(4, 32'hFFF);
        base = nfr;
        wr(0, ctl(0, 1'b1, 15, 1'b0));
        wr(0, ctl(3, 1'b1, 2, 1'b0));
        rd(1, s);
        chk(s[3] == 1'b1, "R8 error on go while busy", int'(s[3]), 1);
        wait_idle();
        chk(nfr - base == 1 && fr_byte[base][0] == 8'h11 && fr_len[base] == 20, "R8 running cycle unaffected",
            int'(fr_byte[base][0]), 8'h11);
        wr(1, 32'h4);
        rd(1, s);
        chk(s[3:2] == 2'b10, "R7 done cleared, error kept", int'(s[3:2]), 2);
        wr(1, 32'h8);
        rd(1, s);
        chk(s[3:2] == 2'b00, "R7 error cleared", int'(s[3:2]), 0);

        // R8: out-of-range entry
        base = nfr;
        wr(0, ctl(6, 1'b0, 0, 1'b0));
        repeat (40) @(negedge clk);
        rd(1, s);
        chk(s[3] == 1'b1 && s[0] == 1'b0 && nfr == base, "R8 out-of-range entry", int'(s[3:0]), 8);
        wr(1, 32'h8);

        // R9: zero prefix register with atomic request
        wr(3, 32'h0);
        base = nfr;
        wr(0, ctl(0, 1'b0, 0, 1'b1));
        wait_idle();
        chk(nfr - base == 1 && fr_byte[base][0] == 8'h11, "R9 no prefix frame when zero", nfr - base, 1);
        wr(1, 32'h4);

        // R10: lock
        wr(1, 32'h8000);
        wr(5, 32'hDEADBEEF);
        wr(4, 32'h0);
        wr(3, 32'h99);
        rd(5, s);
        chk(s == 32'h44332211, "R10 opcode table frozen", int'(s), 32'h44332211);
        rd(4, s);
        chk(s == 32'hFFF, "R10 type table frozen", int'(s), 32'hFFF);
        rd(3, s);
        chk(s == 32'h0, "R10 prefix frozen", int'(s), 0);
        wr(1, 32'h0);
        rd(1, s);
        chk(s[15] == 1'b1, "R10 lock sticky", int'(s[15]), 1);
        base = nfr;
        wr(0, ctl(0, 1'b0, 0, 1'b0));
        wait_idle();
        chk(fr_len[base] == 4 && fr_byte[base][0] == 8'h11, "R10 cycle uses frozen table", fr_len[base], 4);

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #600000;
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule